// File: doc/BRIEF.md
# Multi-channel gamma lookup table

This block applies gamma correction to the pixel streams of a display compositor that drives several output channels. All channels share one lookup store that holds an 8-bit ramp for red, one for green and one for blue per channel. Software fills the store through two bus registers. A pointer register holds a word address and two control flags. A data register takes one table byte per write and can step the pointer forward by itself, so a whole table loads as one burst of data writes.

On the pixel side, every beat carries an 8-bit red, green and blue value and the number of the channel it belongs to. If that channel's gamma enable is high, each component becomes the table byte at its own value. If the enable is low, the pixel leaves unchanged. Both cases take one clock, and the beat's valid flag and channel number travel with it.

The store models power gating. If no channel has gamma enabled and the force flag is clear, the store loses its contents. It drops writes while it is off, and it reads as zero after power returns until software loads it again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, the pointer register reads 0 and `out_valid` is low.
- R2: A read at offset 0x78 returns the pointer register: bit 31 is auto-step, bit 30 is force-on, bits 11:0 are the word address, and every other bit is zero. A read at offset 0xE0 returns zero.
- R3: A data write stores `reg_wdata[7:0]` at the current word address. Channel c occupies words c×768 to c×768+767. Within a channel, the red entries come first at +0..255, then green at +256..511, then blue at +512..767.
- R4: With auto-step set, each data write raises the word address by one. This also happens while the store is powered down. With auto-step clear, the address holds.
- R5: A data write at a word address of 2304 or above changes no entry, and the address stays where it is (no wrap).
- R6: A pixel presented with `pix_valid` high appears one cycle later with `out_valid` high and `out_ch` equal to its channel. A cycle without `pix_valid` gives `out_valid` low one cycle later.
- R7: When the pixel's channel has its `gamma_en` bit set, each output component equals the table entry that its input value selects for that channel and colour. When the bit is clear, or the channel number is 3 or above, the components pass through unchanged.
- R8: While every `gamma_en` bit and the force flag are clear, the store is off. Writes made then are lost. After power returns, every entry reads 0 until it is written again.
- R9: With the force flag set, the store keeps its contents and accepts writes even while every `gamma_en` bit is clear.
- R10: Writes to any offset other than 0x78 and 0xE0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| gamma_en | input | 3 | Gamma enable, one bit per channel |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | 2 | Input pixel channel number |
| pix_r | input | 8 | Input red |
| pix_g | input | 8 | Input green |
| pix_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ch | output | 2 | Output pixel channel number |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
The pointer checks assume that a single bus operation happens per cycle. They assume a data write never shares a cycle with a pointer write. The bench drives the bus only through one write task and one read task, so every access stands alone.

The pass-through check also assumes that `pix_ch` and the colour inputs hold for the whole cycle in which they are sampled. The bench changes them only on falling edges. It holds `pix_valid` low during reset, so that the first output cycle follows from a known input.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // colour components per channel, stored red, green, blue
  localparam int NUM_COMP = 3;

  // channel that owns a linear table word
  function automatic int lut_chan(input int word, input int entries);
    return word / (NUM_COMP * entries);
  endfunction

  // colour component (0 red, 1 green, 2 blue) of a linear table word
  function automatic int lut_comp(input int word, input int entries);
    return (word / entries) % NUM_COMP;
  endfunction

  // entry index inside one component ramp
  function automatic int lut_idx(input int word, input int entries);
    return word % entries;
  endfunction

  // slot inside one per-component bank holding all channels
  function automatic int bank_slot(input int chan, input int idx, input int entries);
    return chan * entries + idx;
  endfunction

endpackage

// File: rtl/gamma_reg_if.sv
module gamma_reg_if #(
  parameter int                BUS_AW   = 8,
  parameter int                ADDR_W   = 12,
  parameter int                TOTAL    = 2304,
  parameter int                COMP_W   = 8,
  parameter logic [BUS_AW-1:0] PTR_OFS  = 'h78,
  parameter logic [BUS_AW-1:0] DATA_OFS = 'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              autoinc,
  output logic              force_on,
  output logic              data_wr,
  output logic [COMP_W-1:0] data_byte
);

  logic ptr_wr;
  logic step;

  assign ptr_wr    = reg_wr && (reg_addr == PTR_OFS);
  assign data_wr   = reg_wr && (reg_addr == DATA_OFS);
  assign data_byte = reg_wdata[COMP_W-1:0];
  assign step      = data_wr && autoinc && (int'(cur_addr) < TOTAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      autoinc  <= 1'b0;
      force_on <= 1'b0;
    end else if (ptr_wr) begin
      cur_addr <= reg_wdata[ADDR_W-1:0];
      autoinc  <= reg_wdata[31];
      force_on <= reg_wdata[30];
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(1);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && (reg_addr == PTR_OFS)) begin
      reg_rdata        = 32'(cur_addr);
      reg_rdata[31]    = autoinc;
      reg_rdata[30]    = force_on;
    end
  end

endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int DEPTH = 768,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          pwr_on,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // loss of power wipes every cell; the wiped state is what reads back
  always_ff @(posedge clk) begin
    if (!pwr_on) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;

endmodule

// File: rtl/gamma_pix_stage.sv
module gamma_pix_stage #(
  parameter int CH_W   = 2,
  parameter int NCOMP  = 3,
  parameter int COMP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [CH_W-1:0]              in_ch,
  input  logic                         lookup,
  input  logic [NCOMP-1:0][COMP_W-1:0] in_comp,
  input  logic [NCOMP-1:0][COMP_W-1:0] lut_comp,
  output logic                         out_valid,
  output logic [CH_W-1:0]              out_ch,
  output logic [NCOMP-1:0][COMP_W-1:0] out_comp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_comp  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_comp <= lookup ? lut_comp : in_comp;
      end
    end
  end

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int                NUM_CH   = 3,
  parameter int                COMP_W   = 8,
  parameter int                BUS_AW   = 8,
  parameter logic [BUS_AW-1:0] PTR_OFS  = 'h78,
  parameter logic [BUS_AW-1:0] DATA_OFS = 'hE0,
  localparam int               CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [COMP_W-1:0] pix_r,
  input  logic [COMP_W-1:0] pix_g,
  input  logic [COMP_W-1:0] pix_b,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [COMP_W-1:0] out_r,
  output logic [COMP_W-1:0] out_g,
  output logic [COMP_W-1:0] out_b
);

  localparam int ENTRIES    = 1 << COMP_W;
  localparam int TOTAL      = NUM_CH * NUM_COMP * ENTRIES;
  localparam int ADDR_W     = $clog2(TOTAL + 1);
  localparam int BANK_DEPTH = NUM_CH * ENTRIES;
  localparam int BANK_AW    = $clog2(BANK_DEPTH);

  // register side
  logic [ADDR_W-1:0]  cur_addr;
  logic               autoinc;
  logic               force_on;
  logic               data_wr;
  logic [COMP_W-1:0]  data_byte;
  logic               in_range;
  logic [1:0]         wr_comp;
  logic [BANK_AW-1:0] wr_slot;
  logic [NUM_COMP-1:0] bank_we;
  logic               bank_we_any;
  logic               pwr_on;

  // pixel side
  logic                            pix_ch_ok;
  logic [CH_W-1:0]                 rd_ch;
  logic                            pix_lookup;
  logic [NUM_COMP-1:0][COMP_W-1:0] pix_in;
  logic [NUM_COMP-1:0][COMP_W-1:0] lut_out;
  logic [NUM_COMP-1:0][COMP_W-1:0] out_comp;

  gamma_reg_if #(
    .BUS_AW  (BUS_AW),
    .ADDR_W  (ADDR_W),
    .TOTAL   (TOTAL),
    .COMP_W  (COMP_W),
    .PTR_OFS (PTR_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cur_addr (cur_addr),
    .autoinc  (autoinc),
    .force_on (force_on),
    .data_wr  (data_wr),
    .data_byte(data_byte)
  );

  // the store stays powered while any channel uses it or software pins it on
  assign pwr_on   = force_on || (|gamma_en);
  assign in_range = int'(cur_addr) < TOTAL;
  assign wr_comp  = 2'(lut_comp(int'(cur_addr), ENTRIES));
  assign wr_slot  = BANK_AW'(bank_slot(lut_chan(int'(cur_addr), ENTRIES),
                                       lut_idx(int'(cur_addr), ENTRIES), ENTRIES));

  assign pix_ch_ok  = int'(pix_ch) < NUM_CH;
  assign rd_ch      = pix_ch_ok ? pix_ch : '0;
  assign pix_lookup = pix_ch_ok && gamma_en[rd_ch];
  assign pix_in     = {pix_b, pix_g, pix_r};

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    logic [BANK_AW-1:0] rd_slot;

    assign bank_we[c] = data_wr && in_range && pwr_on && (wr_comp == 2'(c));
    assign rd_slot    = BANK_AW'(bank_slot(int'(rd_ch), int'(pix_in[c]), ENTRIES));

    gamma_lut_bank #(
      .DEPTH(BANK_DEPTH),
      .AW   (BANK_AW),
      .DW   (COMP_W)
    ) u_bank (
      .clk   (clk),
      .pwr_on(pwr_on),
      .we    (bank_we[c]),
      .waddr (wr_slot),
      .wdata (data_byte),
      .raddr (rd_slot),
      .rdata (lut_out[c])
    );
  end

  assign bank_we_any = |bank_we;

  gamma_pix_stage #(
    .CH_W  (CH_W),
    .NCOMP (NUM_COMP),
    .COMP_W(COMP_W)
  ) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pix_valid),
    .in_ch    (pix_ch),
    .lookup   (pix_lookup),
    .in_comp  (pix_in),
    .lut_comp (lut_out),
    .out_valid(out_valid),
    .out_ch   (out_ch),
    .out_comp (out_comp)
  );

  assign out_r = out_comp[0];
  assign out_g = out_comp[1];
  assign out_b = out_comp[2];

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int TOTAL  = 2304,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 2,
  parameter int COMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [CH_W-1:0]   pix_ch,
  input logic              pix_lookup,
  input logic [COMP_W-1:0] pix_r,
  input logic [COMP_W-1:0] pix_g,
  input logic [COMP_W-1:0] pix_b,
  input logic              out_valid,
  input logic [CH_W-1:0]   out_ch,
  input logic [COMP_W-1:0] out_r,
  input logic [COMP_W-1:0] out_g,
  input logic [COMP_W-1:0] out_b,
  input logic              data_wr,
  input logic              autoinc,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              bank_we_any,
  input logic              pwr_on
);

  // R6
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  // R6
  idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  // R6
  chan_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_ch == $past(pix_ch)));

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_lookup) |=>
      ({out_r, out_g, out_b} == {$past(pix_r), $past(pix_g), $past(pix_b)}));

  // R4
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && autoinc && (int'(cur_addr) < TOTAL)) |=>
      (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !autoinc) |=> $stable(cur_addr));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (int'(cur_addr) >= TOTAL)) |=> $stable(cur_addr));

  // R5
  oob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we_any |-> (int'(cur_addr) < TOTAL));

  // R8
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we_any |-> pwr_on);

endmodule

bind gamma_lut_top gamma_lut_chk #(
  .TOTAL (TOTAL),
  .ADDR_W(ADDR_W),
  .CH_W  (CH_W),
  .COMP_W(COMP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .pix_ch     (pix_ch),
  .pix_lookup (pix_lookup),
  .pix_r      (pix_r),
  .pix_g      (pix_g),
  .pix_b      (pix_b),
  .out_valid  (out_valid),
  .out_ch     (out_ch),
  .out_r      (out_r),
  .out_g      (out_g),
  .out_b      (out_b),
  .data_wr    (data_wr),
  .autoinc    (autoinc),
  .cur_addr   (cur_addr),
  .bank_we_any(bank_we_any),
  .pwr_on     (pwr_on)
);

// File: tb/test_gamma_lut_top.sv
`timescale 1ns/1ps
module test_gamma_lut_top;

  localparam int WORDS = 2304;
  localparam logic [7:0] PTR  = 8'h78;
  localparam logic [7:0] DATA = 8'hE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  gamma_en = '0;
  logic        pix_valid = 1'b0;
  logic [1:0]  pix_ch = '0;
  logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [1:0]  out_ch;
  logic [7:0]  out_r, out_g, out_b;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [WORDS];

  always #5 clk = ~clk;

  gamma_lut_top i_gamma_lut_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_ch(out_ch),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic logic [7:0] ramp(input int ch, input int comp, input int i);
    return 8'((i * 7 + ch * 61 + comp * 113) ^ (i >> 3));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  // one pixel in, result checked one cycle later
  task automatic pix_check(input string req, input logic [1:0] ch, input logic [7:0] r,
                           input logic [7:0] g, input logic [7:0] b, input logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_ch = ch; pix_r = r; pix_g = g; pix_b = b;
    @(negedge clk);
    pix_valid = 1'b0;
    check(req, {7'd0, out_valid, 22'd0, out_ch}, {7'd0, 1'b1, 22'd0, ch});
    check(req, 32'({out_r, out_g, out_b}), 32'(exp));
  endtask

  function automatic logic [23:0] lut_exp(input int ch, input logic [7:0] r,
                                          input logic [7:0] g, input logic [7:0] b);
    return {model[ch * 768 + int'(r)], model[ch * 768 + 256 + int'(g)],
            model[ch * 768 + 512 + int'(b)]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", {31'd0, out_valid}, 32'd0);
    read_check("R1", PTR, 32'h0000_0000);

    // R2 pointer read-back, data register reads zero
    bus_write(PTR, 32'hC000_0123);
    read_check("R2", PTR, 32'hC000_0123);
    bus_write(PTR, 32'hFFFF_FFFF);
    read_check("R2", PTR, 32'hC000_0FFF);
    read_check("R2", DATA, 32'h0);

    // R10 other offsets have no effect
    bus_write(8'h7C, 32'h0);
    bus_write(8'h00, 32'h1234_5678);
    read_check("R10", PTR, 32'hC000_0FFF);

    // R5 write far beyond the table: address holds
    bus_write(DATA, 32'h11);
    read_check("R5", PTR, 32'hC000_0FFF);

    // R3 load the whole table channel-major, R then G then B, junk above bit 7
    bus_write(PTR, 32'hC000_0000);
    for (int ch = 0; ch < 3; ch++)
      for (int comp = 0; comp < 3; comp++)
        for (int i = 0; i < 256; i++) begin
          model[ch * 768 + comp * 256 + i] = ramp(ch, comp, i);
          bus_write(DATA, {24'(ch * 4099 + i * 17 + 1), ramp(ch, comp, i)});
        end
    // R4 address advanced once per write
    read_check("R4", PTR, 32'hC000_0000 | 32'(WORDS));
    // R5 one past the end: ignored, no wrap
    bus_write(DATA, 32'h55);
    read_check("R5", PTR, 32'hC000_0000 | 32'(WORDS));

    // R4 single write with auto-step off: ch1 green idx5 = word 1029
    bus_write(PTR, 32'h4000_0405);
    bus_write(DATA, 32'hFFFF_FF5A);
    model[1029] = 8'h5A;
    read_check("R4", PTR, 32'h4000_0405);

    // R7 R3 full lookup sweep, each component indexed differently
    gamma_en = 3'b111;
    for (int ch = 0; ch < 3; ch++)
      for (int i = 0; i < 256; i++)
        pix_check("R7", 2'(ch), 8'(i), 8'(255 - i), 8'(i) ^ 8'h5A,
                  lut_exp(ch, 8'(i), 8'(255 - i), 8'(i) ^ 8'h5A));
    // R5 word 0 untouched by the out-of-range write
    pix_check("R5", 2'd0, 8'd0, 8'd0, 8'd0, lut_exp(0, 8'd0, 8'd0, 8'd0));

    // R6 idle cycle gives no output
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd0);

    // R7 bypass on disabled and out-of-range channels
    gamma_en = 3'b010;
    for (int k = 0; k < 8; k++) begin
      pix_check("R7", 2'd0, 8'(k * 31), 8'(k * 13 + 2), 8'(200 - k), {8'(k * 31), 8'(k * 13 + 2), 8'(200 - k)});
      pix_check("R7", 2'd1, 8'(k * 31), 8'(k * 13 + 2), 8'(200 - k), lut_exp(1, 8'(k * 31), 8'(k * 13 + 2), 8'(200 - k)));
      pix_check("R7", 2'd2, 8'(k * 9), 8'(k), 8'(k * 3), {8'(k * 9), 8'(k), 8'(k * 3)});
      pix_check("R7", 2'd3, 8'(k * 5), 8'(k + 100), 8'(k * 29), {8'(k * 5), 8'(k + 100), 8'(k * 29)});
    end

    // R9 force flag keeps contents with every enable clear
    gamma_en = 3'b000;
    repeat (5) @(negedge clk);
    bus_write(DATA, 32'h0000_00C3);   // word 1029 still pointed at, store forced on
    model[1029] = 8'hC3;
    gamma_en = 3'b011;
    for (int i = 0; i < 256; i++)
      pix_check("R9", 2'd0, 8'(i), 8'(i), 8'(i), lut_exp(0, 8'(i), 8'(i), 8'(i)));
    pix_check("R9", 2'd1, 8'd0, 8'd5, 8'd0, lut_exp(1, 8'd0, 8'd5, 8'd0));

    // R8 power down: contents lost, writes dropped, address still steps
    gamma_en = 3'b000;
    bus_write(PTR, 32'h8000_0000);
    repeat (3) @(negedge clk);
    bus_write(DATA, 32'h77);
    read_check("R4", PTR, 32'h8000_0001);
    gamma_en = 3'b111;
    for (int ch = 0; ch < 3; ch++)
      for (int i = 0; i < 256; i += 3)
        pix_check("R8", 2'(ch), 8'(i), 8'(i + 1), 8'(i + 2), 24'h0);
    // R8 rewrite once powered: ch2 blue idx200 = word 2248
    bus_write(PTR, 32'(2248));
    bus_write(DATA, 32'h3C);
    pix_check("R8", 2'd2, 8'd0, 8'd0, 8'd200, 24'h00_003C);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule